// File: doc/BRIEF.md
# Gear-Adaptive Bus Clock Divider

This block produces the clocks that go with a serial audio bus. The bus runs at a root frequency divided by a power of two. A 4-bit clock gear code picks the power. Gear 10 is the fastest and passes the root frequency through, and gear 1 divides it by 512. The block works in one of two modes.

- **Framer mode:** one of two system clocks, already running at the root frequency, is divided down to the bus rate of the current gear. The result is driven out on the bus clock pin, and the pin's output enable is raised.
- **Follower mode:** the bus clock arrives from the bus. A divider that tracks the current gear turns it into a reference clock for the local frequency loops. The reference runs at the rate that a programmed reference gear would give. It is switched off when the bus runs slower than that rate.

Every divided clock comes from a free-running 9-bit counter and one selected counter bit. Gear changes are taken only when the counter wraps, which is the point where every divided output is low. Output enables are re-timed on the falling edge of their source clock. A change of system clock source goes through a break-before-make handshake.

Top module: `gear_clk_div`

## Requirements
- R1: In framer mode with gear code G in 1..10, `busclk_out` has a period of 2^(10-G) cycles of the selected system clock and a 50% duty cycle.
- R2: `src_sel` = 0 selects `sys_clk_a` as the root clock and `src_sel` = 1 selects `sys_clk_b`.
- R3: While the root source changes over, `busclk_out` has no high or low phase shorter than half a period of the faster system clock, and the two source gates are never open together.
- R4: `busclk_oe` is high exactly when `framer_mode` is 1. In follower mode `busclk_out` is held low.
- R5: In follower mode with 1 <= `ref_gear` <= `cur_gear` <= 10, `ref_clk` has a period of 2^(`cur_gear` - `ref_gear`) cycles of `busclk_in` and a 50% duty cycle, and `ref_valid` is 1.
- R6: In follower mode with both codes in 1..10 and `cur_gear` < `ref_gear`, `ref_clk` stays low and `ref_valid` is 0.
- R7: A gear code of 0 or 11..15 counts as invalid. An invalid `cur_gear` in framer mode holds `busclk_out` low. An invalid code in either gear field in follower mode holds `ref_clk` low with `ref_valid` at 0.
- R8: A new gear, a new reference gear, or a new validity takes effect only at the next wrap of a 512-count divider cycle. That is within 520 source cycles. No output phase across the change is shorter than the smaller of the old and new half periods.
- R9: In framer mode `ref_clk` is low and `ref_valid` is 0.
- R10: While `rst_n` is low, `busclk_out`, `ref_clk` and `ref_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all clock domains |
| sys_clk_a | input | 1 | System clock candidate 0 at root frequency |
| sys_clk_b | input | 1 | System clock candidate 1 at root frequency |
| src_sel | input | 1 | Root clock choice: 0 = sys_clk_a, 1 = sys_clk_b |
| framer_mode | input | 1 | 1 = this block drives the bus clock, 0 = follower |
| busclk_in | input | 1 | Bus clock received in follower mode |
| cur_gear | input | 4 | Current bus clock gear, valid codes 1..10 |
| ref_gear | input | 4 | Requested reference gear, valid codes 1..10 |
| busclk_out | output | 1 | Divided bus clock for the pin driver |
| busclk_oe | output | 1 | Output enable of the bus clock pin |
| ref_clk | output | 1 | Gear-tracking reference clock |
| ref_valid | output | 1 | Reference clock is running at the requested rate |

## Verification
The bench sweeps every framer gear code and every pair of current and reference gear codes in follower mode. Each output period and high time is compared with a power of two computed from the codes. A wrong shift would show up as a period off by a factor of two. An off-by-one comparison would show up as a live reference at the single pairs where the two gears are equal or differ by one. The bench switches the root source at gear 10 and steps the gear while the divider runs. It tracks the narrowest phase seen in those windows. A mux without the handshake, or a divider that swaps bits mid-count, leaves a sliver pulse below the allowed width. Invalid codes at both ends of the 4-bit range are covered by the sweep. A design that only range-checks one side would let a clock through on codes 0 or 11..15.

// File: rtl/gear_clk_div.sv
module gear_clk_div #(
  parameter int GEAR_W   = 4,
  parameter int TOP_GEAR = 10
) (
  input  logic              rst_n,
  input  logic              sys_clk_a,
  input  logic              sys_clk_b,
  input  logic              src_sel,
  input  logic              framer_mode,
  input  logic              busclk_in,
  input  logic [GEAR_W-1:0] cur_gear,
  input  logic [GEAR_W-1:0] ref_gear,
  output logic              busclk_out,
  output logic              busclk_oe,
  output logic              ref_clk,
  output logic              ref_valid
);
  localparam int CNT_W = TOP_GEAR - 1;
  localparam int KW    = $clog2(TOP_GEAR + 1);

  function automatic logic gear_ok(input logic [GEAR_W-1:0] g);
    return (g != '0) && (g <= GEAR_W'(TOP_GEAR));
  endfunction

  // break-before-make root clock selection
  logic a_sync, a_en, b_sync, b_en, root_clk;

  always_ff @(posedge sys_clk_a or negedge rst_n)
    if (!rst_n) a_sync <= 1'b0;
    else        a_sync <= !src_sel && !b_en;

  always_ff @(negedge sys_clk_a or negedge rst_n)
    if (!rst_n) a_en <= 1'b0;
    else        a_en <= a_sync;

  always_ff @(posedge sys_clk_b or negedge rst_n)
    if (!rst_n) b_sync <= 1'b0;
    else        b_sync <= src_sel && !a_en;

  always_ff @(negedge sys_clk_b or negedge rst_n)
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= b_sync;

  assign root_clk = (sys_clk_a & a_en) | (sys_clk_b & b_en);

  // framer path: root clock down to the bus rate
  logic [CNT_W-1:0] r_cnt;
  logic [KW-1:0]    r_k;
  logic             r_on, r_div, r_pass, r_gate;

  always_ff @(posedge root_clk or negedge rst_n)
    if (!rst_n) begin
      r_cnt <= '0;
      r_k   <= '0;
      r_on  <= 1'b0;
    end else begin
      r_cnt <= r_cnt + 1'b1;
      if (&r_cnt) begin
        r_on <= framer_mode && gear_ok(cur_gear);
        r_k  <= gear_ok(cur_gear) ? KW'(GEAR_W'(TOP_GEAR) - cur_gear) : '0;
      end
    end

  always_comb r_div = (r_k == '0) ? 1'b0 : r_cnt[r_k - KW'(1)];

  always_ff @(negedge root_clk or negedge rst_n)
    if (!rst_n) begin
      r_pass <= 1'b0;
      r_gate <= 1'b0;
    end else begin
      r_pass <= r_on && (r_k == '0);
      r_gate <= r_on && (r_k != '0);
    end

  assign busclk_out = ((root_clk & r_pass) | (r_div & r_gate)) & framer_mode;
  assign busclk_oe  = framer_mode;

  // follower path: incoming bus clock down to the reference rate
  logic [CNT_W-1:0] f_cnt;
  logic [KW-1:0]    f_k;
  logic             f_on, f_div, f_pass, f_gate;

  always_ff @(posedge busclk_in or negedge rst_n)
    if (!rst_n) begin
      f_cnt <= '0;
      f_k   <= '0;
      f_on  <= 1'b0;
    end else begin
      f_cnt <= f_cnt + 1'b1;
      if (&f_cnt) begin
        f_on <= !framer_mode && gear_ok(cur_gear) && gear_ok(ref_gear)
                && (cur_gear >= ref_gear);
        f_k  <= (cur_gear >= ref_gear) ? KW'(cur_gear - ref_gear) : '0;
      end
    end

  always_comb f_div = (f_k == '0) ? 1'b0 : f_cnt[f_k - KW'(1)];

  always_ff @(negedge busclk_in or negedge rst_n)
    if (!rst_n) begin
      f_pass <= 1'b0;
      f_gate <= 1'b0;
    end else begin
      f_pass <= f_on && (f_k == '0);
      f_gate <= f_on && (f_k != '0);
    end

  assign ref_clk   = ((busclk_in & f_pass) | (f_div & f_gate)) & !framer_mode;
  assign ref_valid = f_on & !framer_mode;
endmodule

// File: rtl/gear_clk_div_chk.sv
module gear_clk_div_chk #(
  parameter int GEAR_W = 4,
  parameter int CNT_W  = 9,
  parameter int KW     = 4
) (
  input logic              rst_n,
  input logic              sys_clk_a,
  input logic              root_clk,
  input logic              busclk_in,
  input logic              a_en,
  input logic              b_en,
  input logic [CNT_W-1:0]  r_cnt,
  input logic [CNT_W-1:0]  f_cnt,
  input logic [KW-1:0]     r_k,
  input logic [KW-1:0]     f_k,
  input logic              f_on,
  input logic [GEAR_W-1:0] cur_gear,
  input logic [GEAR_W-1:0] ref_gear
);
  assert_src_exclusive_R3: assert property (@(posedge sys_clk_a) disable iff (!rst_n)
    $onehot0({a_en, b_en}));

  assert_root_ratio_at_wrap_R8: assert property (@(posedge root_clk) disable iff (!rst_n)
    !$stable(r_k) |-> (r_cnt == '0));

  assert_ref_ratio_at_wrap_R8: assert property (@(posedge busclk_in) disable iff (!rst_n)
    !$stable(f_k) |-> (f_cnt == '0));

  assert_ref_valid_at_wrap_R8: assert property (@(posedge busclk_in) disable iff (!rst_n)
    !$stable(f_on) |-> (f_cnt == '0));

  assert_ref_off_below_gear_R6: assert property (@(posedge busclk_in) disable iff (!rst_n)
    ((f_cnt == '0) && ($past(cur_gear) < $past(ref_gear))) |-> !f_on);
endmodule

bind gear_clk_div gear_clk_div_chk #(.GEAR_W(GEAR_W), .CNT_W(CNT_W), .KW(KW)) u_chk (
  .rst_n(rst_n), .sys_clk_a(sys_clk_a), .root_clk(root_clk), .busclk_in(busclk_in),
  .a_en(a_en), .b_en(b_en), .r_cnt(r_cnt), .f_cnt(f_cnt), .r_k(r_k), .f_k(f_k),
  .f_on(f_on), .cur_gear(cur_gear), .ref_gear(ref_gear)
);

// File: tb/tb_gear_clk_div.sv
`timescale 1ns/100ps
module tb_gear_clk_div;
  logic rst_n = 1'b0, sys_clk_a = 1'b0, sys_clk_b = 1'b0, busclk_in = 1'b0;
  logic src_sel = 1'b0, framer_mode = 1'b1;
  logic [3:0] cur_gear = 4'd10, ref_gear = 4'd1;
  logic busclk_out, busclk_oe, ref_clk, ref_valid;

  gear_clk_div dut (
    .rst_n(rst_n), .sys_clk_a(sys_clk_a), .sys_clk_b(sys_clk_b), .src_sel(src_sel),
    .framer_mode(framer_mode), .busclk_in(busclk_in), .cur_gear(cur_gear),
    .ref_gear(ref_gear), .busclk_out(busclk_out), .busclk_oe(busclk_oe),
    .ref_clk(ref_clk), .ref_valid(ref_valid)
  );

  initial forever #5 sys_clk_a = ~sys_clk_a;
  initial forever #7 sys_clk_b = ~sys_clk_b;
  initial forever #2 busclk_in = ~busclk_in;

  int  n_vec = 0, n_bad = 0;
  real bo_rise = 0, bo_prev = 0, bo_fall = 0, bo_hi = 0, bo_min = 1e9;
  real rf_rise = 0, rf_prev = 0, rf_fall = 0, rf_hi = 0, rf_min = 1e9;
  int  bo_n = 0, rf_n = 0;

  always @(posedge busclk_out) begin
    bo_prev = bo_rise; bo_rise = $realtime; bo_n++;
    if ($realtime - bo_fall < bo_min) bo_min = $realtime - bo_fall;
  end
  always @(negedge busclk_out) begin
    bo_fall = $realtime; bo_hi = $realtime - bo_rise;
    if (bo_hi < bo_min) bo_min = bo_hi;
  end
  always @(posedge ref_clk) begin
    rf_prev = rf_rise; rf_rise = $realtime; rf_n++;
    if ($realtime - rf_fall < rf_min) rf_min = $realtime - rf_fall;
  end
  always @(negedge ref_clk) begin
    rf_fall = $realtime; rf_hi = $realtime - rf_rise;
    if (rf_hi < rf_min) rf_min = rf_hi;
  end

  function automatic bit near(input real a, input real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input real act, input real exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", tag, what, act, exp);
    end
  endtask

  task automatic expect_clock(input bit use_ref, input real t, input string tag);
    int n0;
    n0 = use_ref ? rf_n : bo_n;
    #(3.0 * t + 1.0);
    if (use_ref) begin
      chk(rf_n - n0 >= 2, tag, "ref_clk rising edges", rf_n - n0, 2);
      chk(near(rf_rise - rf_prev, t), tag, "ref_clk period", rf_rise - rf_prev, t);
      chk(near(rf_hi, t / 2.0), tag, "ref_clk high time", rf_hi, t / 2.0);
    end else begin
      chk(bo_n - n0 >= 2, tag, "busclk_out rising edges", bo_n - n0, 2);
      chk(near(bo_rise - bo_prev, t), tag, "busclk_out period", bo_rise - bo_prev, t);
      chk(near(bo_hi, t / 2.0), tag, "busclk_out high time", bo_hi, t / 2.0);
    end
  endtask

  task automatic expect_quiet(input bit use_ref, input real window, input string tag);
    int n0;
    n0 = use_ref ? rf_n : bo_n;
    #(window);
    if (use_ref)
      chk(rf_n == n0 && !ref_clk && !ref_valid, tag, "ref_clk edges / ref_valid",
          rf_n - n0 + ref_valid, 0);
    else
      chk(bo_n == n0 && !busclk_out, tag, "busclk_out edges", bo_n - n0, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1900000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    #52.3;
    chk(!busclk_out, "R10", "busclk_out in reset", busclk_out, 0);
    chk(!ref_clk, "R10", "ref_clk in reset", ref_clk, 0);
    chk(!ref_valid, "R10", "ref_valid in reset", ref_valid, 0);
    rst_n = 1'b1;

    // framer sweep over every gear code, source A (10 ns)
    for (int g = 0; g < 16; g++) begin
      cur_gear = 4'(g);
      #(520 * 10);
      if (g >= 1 && g <= 10) begin
        int r0;
        r0 = rf_n;
        expect_clock(1'b0, 10.0 * (1 << (10 - g)), "R1");
        chk(busclk_oe, "R4", "busclk_oe in framer mode", busclk_oe, 1);
        chk(rf_n == r0 && !ref_valid, "R9", "reference in framer mode", rf_n - r0 + ref_valid, 0);
      end else begin
        expect_quiet(1'b0, 640.0, "R7");
      end
    end

    // source B (14 ns)
    src_sel = 1'b1;
    foreach (cur_gear[i]) ;
    for (int j = 0; j < 3; j++) begin
      int g;
      g = (j == 0) ? 10 : (j == 1) ? 7 : 1;
      cur_gear = 4'(g);
      #(520 * 14 + 100);
      expect_clock(1'b0, 14.0 * (1 << (10 - g)), "R2");
    end

    // glitch-free source change at gear 10
    cur_gear = 4'd10;
    src_sel  = 1'b0;
    #(600 * 14);
    bo_min  = 1e9;
    src_sel = 1'b1;
    #300;
    src_sel = 1'b0;
    #300;
    chk(bo_min >= 4.99, "R3", "narrowest busclk_out phase", bo_min, 5.0);
    expect_clock(1'b0, 10.0, "R3");

    // framer gear step 7 -> 6 while running
    cur_gear = 4'd7;
    #5300;
    bo_min   = 1e9;
    cur_gear = 4'd6;
    #5300;
    chk(bo_min >= 39.9, "R8", "narrowest phase across gear step", bo_min, 40.0);
    expect_clock(1'b0, 160.0, "R8");

    // follower mode
    framer_mode = 1'b0;
    #100;
    chk(!busclk_oe, "R4", "busclk_oe in follower mode", busclk_oe, 0);
    expect_quiet(1'b0, 640.0, "R4");

    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 16; r++) begin
        bit c_ok, r_ok;
        cur_gear = 4'(c);
        ref_gear = 4'(r);
        c_ok = (c >= 1 && c <= 10);
        r_ok = (r >= 1 && r <= 10);
        #(520 * 4);
        if (c_ok && r_ok && c >= r) begin
          expect_clock(1'b1, 4.0 * (1 << (c - r)), "R5");
          chk(ref_valid, "R5", "ref_valid with reachable rate", ref_valid, 1);
        end else if (c_ok && r_ok) begin
          expect_quiet(1'b1, 256.0, "R6");
        end else begin
          expect_quiet(1'b1, 256.0, "R7");
        end
      end
    end

    // reference gear step while running: ratio 8 -> 16
    cur_gear = 4'd6;
    ref_gear = 4'd3;
    #(520 * 4);
    rf_min   = 1e9;
    ref_gear = 4'd2;
    #(520 * 4);
    chk(rf_min >= 15.9, "R8", "narrowest ref_clk phase across step", rf_min, 16.0);
    expect_clock(1'b1, 64.0, "R8");

    framer_mode = 1'b1;
    #10.3;
    chk(!ref_valid && !ref_clk, "R9", "reference after entering framer mode",
        ref_valid + ref_clk, 0);

    finish_run();
  end
endmodule